// File: doc/BRIEF.md
# Translation Buffer with Page Protection

This block is a small fully associative translation cache for a paged memory system with 4 KiB pages. A lookup presents a 32-bit virtual address, an access kind and the privilege of the requester. The upper 20 bits are compared against every stored page number at once. The stored frame number then replaces them, and the low 12 bits pass through unchanged. The response arrives one cycle after the request and is exactly one of three outcomes: a hit with a physical address, a miss, or a fault with a 2-bit cause code.

Every matching lookup is also checked against the page's stored attributes: presence, supervisor-only, writable and executable. A permitted access marks the entry as used, and a permitted write also marks it as modified. The response reports what those two flags held before the access. A fill port installs a translation together with its attributes. A flush input drops every translation in one cycle. Walking page tables is left to the surrounding logic.

Top module: `xlat_buffer`

## Requirements
- R1: A request whose page number matches a valid entry, with no protection fault, gives rspHit one cycle later with rspPaddr equal to the stored 20-bit frame number joined to request address bits [11:0].
- R2: Each request gives exactly one of rspHit, rspMiss or rspFault in the next cycle, and none of them is raised without a request. A request matching no valid entry gives rspMiss with rspPaddr zero.
- R3: A write (reqKind 1) to a matched page whose writable attribute is 0 gives rspFault with rspCause 2 and no hit.
- R4: A fetch (reqKind 2) to a matched page whose execute attribute is 0 gives rspFault with rspCause 3. reqKind 0 is a read, and reqKind 3 is treated as a read.
- R5: A request with reqUser 1 to a page whose user attribute is 0 gives rspFault with rspCause 1. The same access with reqUser 0 is allowed.
- R6: A matched page whose present attribute is 0 gives rspFault with rspCause 0, whatever the access. When several checks fail, the cause is chosen in this order: absent (0), privilege (1), read-only (2), no-execute (3).
- R7: rspWasAccessed on a hit reports the entry's used flag from before the access. Each hit sets the flag. A faulting access leaves it unchanged.
- R8: rspWasDirty on a hit reports the entry's modified flag from before the access. Only a hitting write sets it.
- R9: A fill whose page number matches a valid entry rewrites that entry in place. Otherwise the fill takes the lowest-numbered invalid entry. Every fill clears the entry's used and modified flags.
- R10: When all 32 entries are valid, a fill of a new page number evicts the entry at a round-robin pointer. The pointer starts at entry 0 after reset and moves on by one after each eviction.
- R11: A flush pulse invalidates every entry at the next clock edge, so a request issued in the following cycle misses. Flush takes priority over a fill in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Lookup request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| reqUser | input | 1 | 1 for user privilege, 0 for supervisor |
| fillValid | input | 1 | Install a translation |
| fillVpn | input | 20 | Virtual page number to install |
| fillPfn | input | 20 | Physical frame number to install |
| fillWritable | input | 1 | Page may be written |
| fillExec | input | 1 | Page may be fetched from |
| fillUser | input | 1 | Page is open to user privilege |
| fillPresent | input | 1 | Page is resident |
| flush | input | 1 | Invalidate all entries |
| rspHit | output | 1 | Translation succeeded |
| rspMiss | output | 1 | No valid entry matched |
| rspFault | output | 1 | Entry matched but the access is denied |
| rspCause | output | 2 | Fault cause: 0 absent, 1 privilege, 2 read-only, 3 no-execute |
| rspPaddr | output | 32 | Physical address on a hit, zero otherwise |
| rspWasAccessed | output | 1 | Used flag of the hit entry before this access |
| rspWasDirty | output | 1 | Modified flag of the hit entry before this access |

## Verification
Every response, together with its cause, address and flag values, is registered once. It is therefore due exactly one clock after the edge that samples the request. The bench drives requests on the falling edge and reads the outputs on the next falling edge, halfway through the response cycle. A fill or flush takes effect at the edge that samples it. The bench never issues a request in the same cycle as a fill or flush. Each lookup that follows a fill or flush starts on a later falling edge, so the lookup sees the updated contents.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = ADDR_W - OFF_W;
  localparam int PFN_W = 20;
  localparam int MAX_IDX_W = 8;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } accKind_t;

  typedef enum logic [1:0] {
    CAUSE_ABSENT = 2'd0,
    CAUSE_PRIV   = 2'd1,
    CAUSE_RDONLY = 2'd2,
    CAUSE_NOEXEC = 2'd3
  } faultCause_t;

  typedef struct packed {
    logic writable;
    logic exec;
    logic user;
    logic present;
  } pageAttr_t;

  typedef struct packed {
    logic                 doFlush;
    logic                 doFill;
    logic [MAX_IDX_W-1:0] fillIdx;
    logic                 doTouch;
    logic                 touchDirty;
    logic [MAX_IDX_W-1:0] touchIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  pageAttr_t         fillAttr,
  input  logic [VPN_W-1:0]  lookupVpn,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] lookupHitVec,
  output logic [ENTRIES-1:0] fillHitVec,
  output logic [PFN_W-1:0]  selPfn,
  output pageAttr_t         selAttr,
  output logic              selAcc,
  output logic              selDirty
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] accQ;
  logic [ENTRIES-1:0] dirtyQ;
  logic [VPN_W-1:0]   vpnArr  [ENTRIES];
  logic [PFN_W-1:0]   pfnArr  [ENTRIES];
  pageAttr_t          attrArr [ENTRIES];

  logic [IDX_W-1:0] fIdx;
  logic [IDX_W-1:0] tIdx;
  assign fIdx = stb.fillIdx[IDX_W-1:0];
  assign tIdx = stb.touchIdx[IDX_W-1:0];
  assign validVec = validQ;

  // Parallel tag comparators, one per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lookupHitVec[g] = validQ[g] && (vpnArr[g] == lookupVpn);
    assign fillHitVec[g]   = validQ[g] && (vpnArr[g] == fillVpn);
  end

  // AND-OR read mux; at most one entry matches
  always_comb begin
    selPfn   = '0;
    selAttr  = '0;
    selAcc   = 1'b0;
    selDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      selPfn   = selPfn | (pfnArr[i] & {PFN_W{lookupHitVec[i]}});
      selAttr  = pageAttr_t'(selAttr | (attrArr[i] & {4{lookupHitVec[i]}}));
      selAcc   = selAcc | (accQ[i] & lookupHitVec[i]);
      selDirty = selDirty | (dirtyQ[i] & lookupHitVec[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      accQ   <= '0;
      dirtyQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnArr[i]  <= '0;
        pfnArr[i]  <= '0;
        attrArr[i] <= '0;
      end
    end else begin
      if (stb.doTouch) begin
        accQ[tIdx] <= 1'b1;
        if (stb.touchDirty) dirtyQ[tIdx] <= 1'b1;
      end
      if (stb.doFill) begin
        vpnArr[fIdx]  <= fillVpn;
        pfnArr[fIdx]  <= fillPfn;
        attrArr[fIdx] <= fillAttr;
        accQ[fIdx]    <= 1'b0;
        dirtyQ[fIdx]  <= 1'b0;
        validQ[fIdx]  <= 1'b1;
      end
      if (stb.doFlush) validQ <= '0;
    end
  end

  // R9: in-place overwrite keeps page numbers unique, so matches stay one-hot
  a_r9_unique_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookupHitVec));
  a_r9_unique_fill_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fillHitVec));
  // R11: flush leaves nothing valid
  a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.doFlush |=> (validQ == '0));
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqVaddr,
  input  logic [1:0]         reqKind,
  input  logic               reqUser,
  input  logic               fillValid,
  input  logic               flush,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] lookupHitVec,
  input  logic [ENTRIES-1:0] fillHitVec,
  input  logic [PFN_W-1:0]   selPfn,
  input  pageAttr_t          selAttr,
  input  logic               selAcc,
  input  logic               selDirty,
  output ctrlStrobe_t        stb,
  output logic               rspHit,
  output logic               rspMiss,
  output logic               rspFault,
  output logic [1:0]         rspCause,
  output logic [ADDR_W-1:0]  rspPaddr,
  output logic               rspWasAccessed,
  output logic               rspWasDirty
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             anyHit, faultNow, isWrite, isFetch, hitOk;
  faultCause_t      causeNow;
  logic [IDX_W-1:0] hitIdx, matchIdx, freeIdx, fillIdx, ptrQ;
  logic             fillMatch, allFull, doFill, evict;

  assign isWrite = (reqKind == ACC_WRITE);
  assign isFetch = (reqKind == ACC_FETCH);
  assign anyHit  = |lookupHitVec;

  // Protection checks in fixed priority order
  always_comb begin
    faultNow = 1'b1;
    causeNow = CAUSE_ABSENT;
    if (!selAttr.present)                 causeNow = CAUSE_ABSENT;
    else if (reqUser && !selAttr.user)    causeNow = CAUSE_PRIV;
    else if (isWrite && !selAttr.writable) causeNow = CAUSE_RDONLY;
    else if (isFetch && !selAttr.exec)    causeNow = CAUSE_NOEXEC;
    else                                   faultNow = 1'b0;
  end

  assign hitOk = reqValid && anyHit && !faultNow;

  // Index encoders
  always_comb begin
    hitIdx   = '0;
    matchIdx = '0;
    freeIdx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookupHitVec[i]) hitIdx = IDX_W'(i);
      if (fillHitVec[i])   matchIdx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign fillMatch = |fillHitVec;
  assign allFull   = &validVec;
  assign doFill    = fillValid && !flush;
  assign evict     = doFill && !fillMatch && allFull;

  always_comb begin
    if (fillMatch)     fillIdx = matchIdx;
    else if (!allFull) fillIdx = freeIdx;
    else               fillIdx = ptrQ;
  end

  always_comb begin
    stb            = '0;
    stb.doFlush    = flush;
    stb.doFill     = doFill;
    stb.fillIdx    = MAX_IDX_W'(fillIdx);
    stb.doTouch    = hitOk;
    stb.touchDirty = isWrite;
    stb.touchIdx   = MAX_IDX_W'(hitIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ           <= '0;
      rspHit         <= 1'b0;
      rspMiss        <= 1'b0;
      rspFault       <= 1'b0;
      rspCause       <= '0;
      rspPaddr       <= '0;
      rspWasAccessed <= 1'b0;
      rspWasDirty    <= 1'b0;
    end else begin
      if (evict) ptrQ <= (ptrQ == LAST_IDX) ? '0 : ptrQ + 1'b1;
      rspHit         <= hitOk;
      rspMiss        <= reqValid && !anyHit;
      rspFault       <= reqValid && anyHit && faultNow;
      rspCause       <= (reqValid && anyHit && faultNow) ? causeNow : CAUSE_ABSENT;
      rspPaddr       <= hitOk ? {selPfn, reqVaddr[OFF_W-1:0]} : '0;
      rspWasAccessed <= hitOk && selAcc;
      rspWasDirty    <= hitOk && selDirty;
    end
  end

  // R2: one outcome per request, none without one
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspHit, rspMiss, rspFault}));
  a_r2_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    (rspHit || rspMiss || rspFault) |-> $past(reqValid));
  // R1: the page offset passes through
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> (rspPaddr[OFF_W-1:0] == $past(reqVaddr[OFF_W-1:0])));
  // R3: a read-only fault comes only from a write
  a_r3_rdonly_from_write: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault && rspCause == CAUSE_RDONLY) |-> ($past(reqKind) == ACC_WRITE));
  // R4: a no-execute fault comes only from a fetch
  a_r4_noexec_from_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault && rspCause == CAUSE_NOEXEC) |-> ($past(reqKind) == ACC_FETCH));
  // R5: a privilege fault comes only from a user request
  a_r5_priv_from_user: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault && rspCause == CAUSE_PRIV) |-> $past(reqUser));
  // R10: the victim pointer moves only on an eviction
  a_r10_ptr_steady: assert property (@(posedge clk) disable iff (!rstN)
    !evict |=> $stable(ptrQ));
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqVaddr,
  input  logic [1:0]  reqKind,
  input  logic        reqUser,
  input  logic        fillValid,
  input  logic [19:0] fillVpn,
  input  logic [19:0] fillPfn,
  input  logic        fillWritable,
  input  logic        fillExec,
  input  logic        fillUser,
  input  logic        fillPresent,
  input  logic        flush,
  output logic        rspHit,
  output logic        rspMiss,
  output logic        rspFault,
  output logic [1:0]  rspCause,
  output logic [31:0] rspPaddr,
  output logic        rspWasAccessed,
  output logic        rspWasDirty
);
  ctrlStrobe_t        stb;
  pageAttr_t          fillAttr, selAttr;
  logic [ENTRIES-1:0] validVec, lookupHitVec, fillHitVec;
  logic [PFN_W-1:0]   selPfn;
  logic               selAcc, selDirty;

  assign fillAttr = '{writable: fillWritable, exec: fillExec,
                      user: fillUser, present: fillPresent};

  xlat_store #(.ENTRIES(ENTRIES)) uStore (
    .clk(clk), .rstN(rstN), .stb(stb),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .fillAttr(fillAttr),
    .lookupVpn(reqVaddr[ADDR_W-1:OFF_W]),
    .validVec(validVec), .lookupHitVec(lookupHitVec), .fillHitVec(fillHitVec),
    .selPfn(selPfn), .selAttr(selAttr), .selAcc(selAcc), .selDirty(selDirty)
  );

  xlat_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqKind(reqKind), .reqUser(reqUser),
    .fillValid(fillValid), .flush(flush),
    .validVec(validVec), .lookupHitVec(lookupHitVec), .fillHitVec(fillHitVec),
    .selPfn(selPfn), .selAttr(selAttr), .selAcc(selAcc), .selDirty(selDirty),
    .stb(stb),
    .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault), .rspCause(rspCause),
    .rspPaddr(rspPaddr), .rspWasAccessed(rspWasAccessed), .rspWasDirty(rspWasDirty)
  );
endmodule

// File: tb/sim_xlat_buffer.sv
module sim_xlat_buffer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [19:0] fillPfn = '0;
  logic        fillWritable = 1'b0, fillExec = 1'b0, fillUser = 1'b0, fillPresent = 1'b0;
  logic        flush = 1'b0;
  logic        rspHit, rspMiss, rspFault, rspWasAccessed, rspWasDirty;
  logic [1:0]  rspCause;
  logic [31:0] rspPaddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xlat_buffer u0 (.*);

  // vector: vaddr, kind, user, outcome (0 hit, 1 miss, 2 fault), cause, paddr
  localparam int NVEC = 14;
  localparam logic [70:0] VEC [NVEC] = '{
    {32'h0001_0ABC, 2'd0, 1'b1, 2'd0, 2'd0, 32'h0021_5ABC}, // R1 read
    {32'h0001_0123, 2'd2, 1'b1, 2'd2, 2'd3, 32'h0}, // R4 no exec
    {32'h0001_1FFF, 2'd1, 1'b1, 2'd2, 2'd2, 32'h0}, // R3 read-only
    {32'h0001_1000, 2'd2, 1'b1, 2'd0, 2'd0, 32'h0030_0000}, // R4 fetch ok
    {32'h0002_0010, 2'd0, 1'b1, 2'd2, 2'd1, 32'h0}, // R5 user denied
    {32'h0002_0010, 2'd1, 1'b0, 2'd0, 2'd0, 32'h0040_0010}, // R5 supervisor ok
    {32'h0003_0004, 2'd0, 1'b0, 2'd2, 2'd0, 32'h0}, // R6 absent
    {32'h0003_0004, 2'd1, 1'b1, 2'd2, 2'd0, 32'h0}, // R6 absent wins
    {32'h0004_0008, 2'd1, 1'b1, 2'd2, 2'd1, 32'h0}, // R6 priv over write
    {32'h0004_0008, 2'd1, 1'b0, 2'd2, 2'd2, 32'h0}, // R6 write fault
    {32'h0004_0008, 2'd2, 1'b0, 2'd2, 2'd3, 32'h0}, // R6 exec fault
    {32'h0005_0000, 2'd0, 1'b0, 2'd1, 2'd0, 32'h0}, // R2 miss
    {32'h0001_0777, 2'd3, 1'b1, 2'd0, 2'd0, 32'h0021_5777}, // R4 kind 3 as read
    {32'hFFFF_F000, 2'd0, 1'b0, 2'd1, 2'd0, 32'h0}  // R2 miss
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called on a falling edge; returns on the next one with the response
  task automatic lookup(input logic [31:0] va, input logic [1:0] kind, input logic user);
    reqValid = 1'b1; reqVaddr = va; reqKind = kind; reqUser = user;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic w, input logic x, input logic u, input logic p);
    fillValid = 1'b1; fillVpn = vpn; fillPfn = pfn;
    fillWritable = w; fillExec = x; fillUser = u; fillPresent = p;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic expectHit(input string req, input logic [31:0] pa);
    check(req, {29'd0, rspHit, rspMiss, rspFault}, 32'd4);
    check(req, rspPaddr, pa);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2: no outcome without a request
    check("R2 reset outcome", {29'd0, rspHit, rspMiss, rspFault}, 32'd0);
    check("R2 reset paddr", rspPaddr, 32'd0);

    fill(20'h00010, 20'h00215, 1, 0, 1, 1);
    fill(20'h00011, 20'h00300, 0, 1, 1, 1);
    fill(20'h00020, 20'h00400, 1, 1, 0, 1);
    fill(20'h00030, 20'h00500, 0, 0, 0, 0);
    fill(20'h00040, 20'h00600, 0, 0, 0, 1);

    for (int i = 0; i < NVEC; i++) begin
      logic [70:0] v;
      v = VEC[i];
      lookup(v[70:39], v[38:37], v[36]);
      check($sformatf("R1/R2 vec%0d hit", i), {31'd0, rspHit}, {31'd0, v[35:34] == 2'd0});
      check($sformatf("R2 vec%0d miss", i), {31'd0, rspMiss}, {31'd0, v[35:34] == 2'd1});
      check($sformatf("R3/R4/R5/R6 vec%0d fault", i), {31'd0, rspFault}, {31'd0, v[35:34] == 2'd2});
      check($sformatf("R6 vec%0d cause", i), {30'd0, rspCause}, {30'd0, v[33:32]});
      check($sformatf("R1 vec%0d paddr", i), rspPaddr, v[31:0]);
    end

    // R7 / R8: used and modified flags
    fill(20'h00070, 20'h00777, 1, 1, 1, 1);
    lookup(32'h0007_0010, 2'd0, 1'b1);
    expectHit("R7 first read", 32'h0077_7010);
    check("R7 first read used", {31'd0, rspWasAccessed}, 32'd0);
    lookup(32'h0007_0020, 2'd0, 1'b1);
    check("R7 second read used", {31'd0, rspWasAccessed}, 32'd1);
    check("R8 read leaves clean", {31'd0, rspWasDirty}, 32'd0);
    lookup(32'h0007_0030, 2'd1, 1'b1);
    check("R8 first write dirty before", {31'd0, rspWasDirty}, 32'd0);
    lookup(32'h0007_0040, 2'd0, 1'b1);
    check("R8 dirty after write", {31'd0, rspWasDirty}, 32'd1);

    // R7: a faulting access does not mark the page used
    fill(20'h00080, 20'h00888, 0, 1, 1, 1);
    lookup(32'h0008_0000, 2'd1, 1'b1);
    check("R7 fault outcome", {29'd0, rspHit, rspMiss, rspFault}, 32'd1);
    lookup(32'h0008_0000, 2'd0, 1'b1);
    check("R7 fault left unused", {31'd0, rspWasAccessed}, 32'd0);

    // R9: in-place rewrite with new frame, flags cleared
    fill(20'h00070, 20'h00999, 1, 1, 1, 1);
    lookup(32'h0007_0ABC, 2'd0, 1'b1);
    expectHit("R9 rewritten frame", 32'h0099_9ABC);
    check("R9 rewrite clears used", {31'd0, rspWasAccessed}, 32'd0);
    check("R9 rewrite clears dirty", {31'd0, rspWasDirty}, 32'd0);

    // R11: flush
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    lookup(32'h0001_0ABC, 2'd0, 1'b1);
    check("R11 miss after flush", {29'd0, rspHit, rspMiss, rspFault}, 32'd2);

    // R9 / R10: fill all 32, then evict round-robin
    for (int i = 0; i < 32; i++) fill(20'h00100 + 20'(i), 20'h00800 + 20'(i), 1, 1, 1, 1);
    lookup(32'h0011_F004, 2'd0, 1'b0);
    expectHit("R9 last slot", 32'h0081_F004);
    fill(20'h00105, 20'h00ABC, 1, 1, 1, 1);
    lookup(32'h0010_5000, 2'd0, 1'b0);
    expectHit("R9 overwrite when full", 32'h00AB_C000);
    fill(20'h00200, 20'h00F00, 1, 1, 1, 1);
    lookup(32'h0010_0000, 2'd0, 1'b0);
    check("R10 entry 0 evicted", {29'd0, rspHit, rspMiss, rspFault}, 32'd2);
    lookup(32'h0010_1000, 2'd0, 1'b0);
    expectHit("R10 entry 1 kept", 32'h0080_1000);
    lookup(32'h0020_0123, 2'd0, 1'b0);
    expectHit("R10 new page", 32'h00F0_0123);
    fill(20'h00201, 20'h00F01, 1, 1, 1, 1);
    lookup(32'h0010_1000, 2'd0, 1'b0);
    check("R10 entry 1 evicted next", {29'd0, rspHit, rspMiss, rspFault}, 32'd2);
    lookup(32'h0010_2000, 2'd0, 1'b0);
    expectHit("R10 entry 2 kept", 32'h0080_2000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule